// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is a bus-mastering DMA engine with one channel. Software programs a memory address, a unit count and a control word through a simple register-write port and then sets a start bit. The engine asks for the system bus. Once the bus is granted, it moves units between a device controller and memory without the CPU. Every unit uses the same handshake: a one-cycle request to the device, a separate memory bus cycle, and then a wait for the device acknowledge. The address and the count change only after that acknowledge.

Each transfer selects how the engine holds the bus. In cycle-stealing mode it gives up the bus after every unit and asks for it again. In burst mode it keeps the bus for a programmed number of units. When the count reaches zero, the engine raises a completion interrupt. The interrupt stays high until software writes a clear bit. Starting a transfer with a count of zero raises the interrupt at once and drives no bus activity.

Top module: `dma_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `bus_req`, `dev_req` and `mem_en` are 0. `cfg_sel` selects the register to write: 0 is the address, 1 is the count, 2 is the control word. Writing a control word with bit 0 (start) set makes `busy` read 1 in the following cycle.
- R2: `dev_req` and `mem_en` are only ever high while `bus_grant` is high. `bus_req` is held from the start of a bus tenure until the grant arrives.
- R3: For each unit, `dev_req` is high for exactly one cycle and `mem_en` is high in the next cycle. The engine then waits, for any number of cycles, until `dev_ack` is high.
- R4: Control bit 2 selects the direction. With 0 (device to memory), the memory cycle is a write (`mem_we`=1) carrying the `dev_rdata` value present during the request cycle. With 1 (memory to device), the memory cycle is a read (`mem_we`=0), and `dev_wdata` holds the `mem_rdata` value while the engine waits for the acknowledge.
- R5: Control bit 3 selects the unit: 0 is a byte and `mem_byte` is 1; 1 is a word. The address advances by 1 for a byte and by 4 for a word, and the count drops by 1, only in the cycle after an accepted `dev_ack`. A transfer of N units ends at start address plus N times the step, with the count at 0.
- R6: When control bit 4 is 0 (cycle stealing), `bus_req` drops in the cycle after every acknowledged unit. It stays low for one cycle and then rises again if units remain.
- R7: When control bit 4 is 1 (burst), each bus tenure carries the burst length from control bits 12:5 in units, or fewer if fewer remain. A burst length of 0 is taken as 1. `bus_req` drops in the cycle after the last unit of the tenure.
- R8: In the cycle after the last unit is acknowledged, `irq` is 1, `busy` is 0 and `bus_req` is 0.
- R9: `irq` stays 1 until a control write with bit 1 (clear) set, after which it reads 0.
- R10: A start with the count register at 0 sets `irq` in the next cycle. `busy` stays 0 and no bus request or bus cycle follows.
- R11: While `busy` is 1, writes to the address register, writes to the count register, and start bits are ignored. The running transfer ends at its original address and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, sticky until cleared |
| cur_addr | output | AW | Current memory address |
| cur_count | output | CW | Units remaining |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| dev_req | output | 1 | One-cycle request to the device controller |
| dev_dir | output | 1 | Direction of the current transfer (1: memory to device) |
| dev_rdata | input | DW | Data from the device, valid while `dev_req` is high |
| dev_wdata | output | DW | Data to the device, valid while waiting for `dev_ack` |
| dev_ack | input | 1 | Device acknowledge that ends a unit |
| mem_en | output | 1 | Memory bus cycle |
| mem_we | output | 1 | Memory cycle is a write |
| mem_byte | output | 1 | Memory cycle is byte-sized |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the `mem_en` cycle |

## Verification
The assertions assume that a granted bus stays granted until the engine drops `bus_req`, and that the grant falls when the request falls. They also assume that `dev_ack` comes only while the engine waits for it, as a single-cycle pulse, and that memory read data is valid in the same cycle as `mem_en`. The bench's arbiter and device model follow these rules. The arbiter holds the grant for as long as the request stays high and waits a random 0 to 3 cycles before granting. The device model raises the acknowledge a random 0 to 3 cycles after each memory cycle, and only for one cycle. Register writes that land while the engine is busy are made on purpose, to confirm that they leave the transfer unchanged.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_DREQ,
    ST_MEM,
    ST_ACK,
    ST_GAP
  } dma_state_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int B_START = 0;
  localparam int B_CLR   = 1;
  localparam int B_DIR   = 2;
  localparam int B_UNIT  = 3;
  localparam int B_MODE  = 4;
  localparam int B_BLEN  = 5;

  // address stride of one unit
  function automatic logic [2:0] unit_stride(input logic word_unit);
    return word_unit ? 3'd4 : 3'd1;
  endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_pkg::*;
#(
  parameter int BLW = 8,
  localparam int FW = B_BLEN + BLW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           busy,
  input  logic [FW-1:0]  wdata,
  output logic           start_p,
  output logic           clr_p,
  output logic           dir_q,
  output logic           unit_q,
  output logic           mode_q,
  output logic [BLW-1:0] blen_q
);

  assign start_p = wr_ctrl && wdata[B_START] && !busy;
  assign clr_p   = wr_ctrl && wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      unit_q <= 1'b0;
      mode_q <= 1'b0;
      blen_q <= '0;
    end else if (wr_ctrl && !busy) begin
      dir_q  <= wdata[B_DIR];
      unit_q <= wdata[B_UNIT];
      mode_q <= wdata[B_MODE];
      blen_q <= wdata[FW-1:B_BLEN];
    end
  end

endmodule

// File: rtl/dma_counters.sv
module dma_counters
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int BLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_addr,
  input  logic           ld_count,
  input  logic [AW-1:0]  addr_in,
  input  logic [CW-1:0]  count_in,
  input  logic           unit_done,
  input  logic           word_unit,
  input  logic           beat_clr,
  input  logic [BLW-1:0] blen,
  output logic [AW-1:0]  addr_q,
  output logic [CW-1:0]  count_q,
  output logic           count_zero,
  output logic           last_unit,
  output logic           burst_end
);

  logic [BLW:0] beat_q;
  logic [BLW:0] limit;

  // a programmed length of zero behaves as one unit per tenure
  assign limit      = (blen == '0) ? {{BLW{1'b0}}, 1'b1} : {1'b0, blen};
  assign burst_end  = (beat_q + 1'b1) >= limit;
  assign count_zero = (count_q == '0);
  assign last_unit  = (count_q == {{(CW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
    end else begin
      if (ld_addr)
        addr_q <= addr_in;
      else if (unit_done)
        addr_q <= addr_q + AW'(unit_stride(word_unit));
      if (ld_count)
        count_q <= count_in;
      else if (unit_done)
        count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         beat_q <= '0;
    else if (beat_clr)  beat_q <= '0;
    else if (unit_done) beat_q <= beat_q + 1'b1;
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_p,
  input  logic count_zero,
  input  logic last_unit,
  input  logic burst_end,
  input  logic burst_mode,
  input  logic bus_grant,
  input  logic dev_ack,
  output logic bus_req,
  output logic dev_req,
  output logic mem_en,
  output logic busy,
  output logic unit_done,
  output logic beat_clr,
  output logic irq_set
);

  dma_state_t st, nxt;

  always_comb begin
    nxt       = st;
    unit_done = 1'b0;
    beat_clr  = 1'b0;
    irq_set   = 1'b0;
    case (st)
      ST_IDLE: if (start_p) begin
        beat_clr = 1'b1;
        if (count_zero) irq_set = 1'b1;
        else            nxt     = ST_ARB;
      end
      ST_ARB:  if (bus_grant) nxt = ST_DREQ;
      ST_DREQ: nxt = ST_MEM;
      ST_MEM:  nxt = ST_ACK;
      ST_ACK: if (dev_ack) begin
        unit_done = 1'b1;
        if (last_unit) begin
          irq_set = 1'b1;
          nxt     = ST_IDLE;
        end else if (!burst_mode || burst_end) begin
          beat_clr = 1'b1;
          nxt      = ST_GAP;
        end else begin
          nxt = ST_DREQ;
        end
      end
      ST_GAP:  nxt = ST_ARB;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign bus_req = (st == ST_ARB) || (st == ST_DREQ) || (st == ST_MEM) || (st == ST_ACK);
  assign dev_req = (st == ST_DREQ);
  assign mem_en  = (st == ST_MEM);
  assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int BLW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          busy,
  output logic          irq,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          dev_req,
  output logic          dev_dir,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] dev_wdata,
  input  logic          dev_ack,
  output logic          mem_en,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int FW = B_BLEN + BLW;

  // named internal events, also used by the bound checker
  logic           start_p, clr_p, unit_done, beat_clr, irq_set;
  logic           count_zero, last_unit, burst_end;
  logic           dir_q, unit_q, mode_q;
  logic [BLW-1:0] blen_q;
  logic           ld_addr, ld_count, wr_ctrl;
  logic [DW-1:0]  data_q;
  logic           irq_q;

  assign ld_addr  = cfg_we && (cfg_sel == SEL_ADDR)  && !busy;
  assign ld_count = cfg_we && (cfg_sel == SEL_COUNT) && !busy;
  assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);

  dma_ctrl_reg #(.BLW(BLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .busy(busy),
    .wdata(cfg_wdata[FW-1:0]), .start_p(start_p), .clr_p(clr_p),
    .dir_q(dir_q), .unit_q(unit_q), .mode_q(mode_q), .blen_q(blen_q)
  );

  dma_counters #(.AW(AW), .CW(CW), .BLW(BLW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_count(ld_count),
    .addr_in(cfg_wdata[AW-1:0]), .count_in(cfg_wdata[CW-1:0]),
    .unit_done(unit_done), .word_unit(unit_q), .beat_clr(beat_clr),
    .blen(blen_q), .addr_q(cur_addr), .count_q(cur_count),
    .count_zero(count_zero), .last_unit(last_unit), .burst_end(burst_end)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .count_zero(count_zero),
    .last_unit(last_unit), .burst_end(burst_end), .burst_mode(mode_q),
    .bus_grant(bus_grant), .dev_ack(dev_ack), .bus_req(bus_req),
    .dev_req(dev_req), .mem_en(mem_en), .busy(busy), .unit_done(unit_done),
    .beat_clr(beat_clr), .irq_set(irq_set)
  );

  // data holding register: device data in the request cycle, memory data in the memory cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                data_q <= '0;
    else if (dev_req && !dir_q) data_q <= dev_rdata;
    else if (mem_en && dir_q)   data_q <= mem_rdata;
  end

  // completion interrupt; a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (clr_p)   irq_q <= 1'b0;
  end

  assign irq       = irq_q;
  assign dev_dir   = dir_q;
  assign dev_wdata = data_q;
  assign mem_we    = mem_en && !dir_q;
  assign mem_byte  = !unit_q;
  assign mem_addr  = cur_addr;
  assign mem_wdata = data_q;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          irq,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_count,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          dev_req,
  input logic          mem_en,
  input logic          unit_done,
  input logic          last_unit,
  input logic          burst_end,
  input logic          mode_q,
  input logic          start_p,
  input logic          clr_p
);

  // R2
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req || mem_en) |-> bus_grant);

  // R3
  mem_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(dev_req));

  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |=> !dev_req);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (cur_count == $past(cur_count) - 1'b1));

  // R11
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_done) |=> $stable(cur_addr));

  // R6
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !mode_q) |=> !bus_req);

  // R7
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && mode_q && !last_unit && !burst_end) |=> bus_req);

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && last_unit) |=> (irq && !busy && !bus_req));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_p) |=> irq);

  // R10
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && cur_count == '0) |=> (irq && !busy && !bus_req));

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_dma_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .cur_addr(cur_addr),
  .cur_count(cur_count), .bus_req(bus_req), .bus_grant(bus_grant),
  .dev_req(dev_req), .mem_en(mem_en), .unit_done(unit_done),
  .last_unit(last_unit), .burst_end(burst_end), .mode_q(mode_q),
  .start_p(start_p), .clr_p(clr_p)
);

// File: tb/test_dma_engine.sv
module test_dma_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        busy, irq, bus_req, dev_req, dev_dir, mem_en, mem_we, mem_byte;
  logic [31:0] cur_addr, mem_addr, mem_wdata, dev_wdata, dev_rdata, mem_rdata;
  logic [15:0] cur_count;
  logic        bus_grant = 1'b0;
  logic        dev_ack = 1'b0;

  int n_chk = 0, n_bad = 0;

  // expected-state trackers
  logic [31:0] e_addr, ack_addr;
  int  e_left, e_lim, ten_units, ten_rem, units_seen, gcnt, gdly, ack_dly;
  bit  e_dir, e_unit, prev_req, prev_dreq, ack_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  // device data follows the remaining count, memory data follows the address
  assign dev_rdata = 32'hC0DE_0000 | {16'd0, cur_count};
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .irq(irq), .cur_addr(cur_addr),
    .cur_count(cur_count), .bus_req(bus_req), .bus_grant(bus_grant),
    .dev_req(dev_req), .dev_dir(dev_dir), .dev_rdata(dev_rdata),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .mem_en(mem_en),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctrl_word(bit start, bit clr, bit dir, bit unit, bit mode, int blen);
    return {19'd0, blen[7:0], mode, unit, dir, clr, start};
  endfunction

  function automatic int stride(bit unit);
    return unit ? 4 : 1;
  endfunction

  function automatic int tenure_size(int rem, int lim);
    return (rem < lim) ? rem : lim;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // bus arbiter and device model, acting away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_req = 0; prev_dreq = 0; ack_wait = 0; gcnt = 0; gdly = 0;
      end else begin
        if (dev_req) chk(bus_grant, "R2 dev_req without grant", 32'(bus_grant), 32'd1);
        if (mem_en)  chk(bus_grant, "R2 mem_en without grant", 32'(bus_grant), 32'd1);
        if (mem_en)  chk(prev_dreq, "R3 mem_en not after dev_req", 32'(prev_dreq), 32'd1);
        if (bus_req && !prev_req) begin ten_rem = e_left; ten_units = 0; end
        if (!bus_req && prev_req)
          chk(ten_units == tenure_size(ten_rem, e_lim), "R6/R7 units per tenure",
              32'(ten_units), 32'(tenure_size(ten_rem, e_lim)));
        prev_req  = bus_req;
        prev_dreq = dev_req;
        // acknowledge
        if (dev_ack) dev_ack = 1'b0;
        else if (ack_wait) begin
          if (ack_dly == 0) begin
            dev_ack  = 1'b1;
            ack_wait = 0;
            if (e_dir) chk(dev_wdata == (ack_addr ^ 32'h5A5A_0000), "R4 dev_wdata",
                           dev_wdata, ack_addr ^ 32'h5A5A_0000);
          end else ack_dly--;
        end
        // memory cycle
        if (mem_en) begin
          chk(mem_addr == e_addr, "R5 mem_addr", mem_addr, e_addr);
          chk(mem_we == !e_dir, "R4 mem_we", 32'(mem_we), 32'(!e_dir));
          chk(mem_byte == !e_unit, "R5 mem_byte", 32'(mem_byte), 32'(!e_unit));
          if (!e_dir) chk(mem_wdata == (32'hC0DE_0000 | 32'(e_left)), "R4 mem_wdata",
                          mem_wdata, 32'hC0DE_0000 | 32'(e_left));
          ack_addr = e_addr;
          e_addr   = e_addr + 32'(stride(e_unit));
          e_left--;
          ten_units++;
          units_seen++;
          ack_wait = 1;
          ack_dly  = $urandom_range(0, 3);
        end
        // grant
        if (!bus_req) begin
          bus_grant = 1'b0; gcnt = 0;
        end else if (!bus_grant) begin
          if (gcnt >= gdly) begin bus_grant = 1'b1; gdly = $urandom_range(0, 3); end
          else gcnt++;
        end
      end
    end
  end

  task automatic run_xfer(input logic [31:0] a, input int cnt, input bit dir, input bit unit,
                          input bit mode, input int blen, input bit poke);
    logic [31:0] fin;
    e_addr = a; e_left = cnt; e_dir = dir; e_unit = unit;
    e_lim = mode ? ((blen == 0) ? 1 : blen) : 1;
    units_seen = 0;
    fin = a + 32'(cnt * stride(unit));
    wr(2'd0, a);
    wr(2'd1, 32'(cnt));
    wr(2'd2, ctrl_word(1, 0, dir, unit, mode, blen));
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R11 still busy before pokes", 32'(busy), 32'd1);
      wr(2'd0, 32'hDEAD_0000);
      wr(2'd1, 32'd100);
      wr(2'd2, ctrl_word(1, 0, !dir, !unit, !mode, 7));
    end
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, "R8 irq at end", 32'(irq), 32'd1);
    chk(busy == 1'b0, "R8 busy low at end", 32'(busy), 32'd0);
    chk(bus_req == 1'b0, "R8 bus_req low at end", 32'(bus_req), 32'd0);
    chk(units_seen == cnt, poke ? "R11 unit count" : "R5 unit count", 32'(units_seen), 32'(cnt));
    chk(cur_count == 16'd0, "R5 final count", 32'(cur_count), 32'd0);
    chk(cur_addr == fin, poke ? "R11 final address" : "R5 final address", cur_addr, fin);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", 32'(irq), 32'd1);
    wr(2'd2, ctrl_word(0, 1, 0, 0, 0, 0));
    chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy reset", 32'(busy), 0);
    chk(irq == 0, "R1 irq reset", 32'(irq), 0);
    chk(bus_req == 0, "R1 bus_req reset", 32'(bus_req), 0);
    chk(dev_req == 0 && mem_en == 0, "R1 bus cycles reset", 32'({dev_req, mem_en}), 0);

    // R10 zero count
    e_lim = 1;
    wr(2'd1, 32'd0);
    wr(2'd2, ctrl_word(1, 0, 0, 1, 0, 0));
    chk(irq == 1'b1, "R10 irq at once", 32'(irq), 1);
    chk(busy == 1'b0, "R10 not busy", 32'(busy), 0);
    for (int i = 0; i < 5; i++) begin
      chk(!bus_req && !mem_en && !dev_req, "R10 no bus activity", 32'({bus_req, dev_req, mem_en}), 0);
      @(negedge clk);
    end
    wr(2'd2, ctrl_word(0, 1, 0, 0, 0, 0));
    chk(irq == 1'b0, "R9 clear after zero start", 32'(irq), 0);

    // directed cases
    run_xfer(32'h0000_1000, 5, 0, 1, 0, 0, 0);  // R6 steal, word, device to memory
    run_xfer(32'h0000_2003, 7, 0, 0, 1, 3, 0);  // R7 burst of 3, byte
    run_xfer(32'h0000_3000, 4, 1, 1, 1, 0, 0);  // R7 burst length 0, memory to device
    run_xfer(32'h0000_4000, 1, 1, 0, 1, 8, 0);  // single unit
    run_xfer(32'hFFFF_FFFC, 3, 0, 1, 1, 2, 0);  // address wrap
    run_xfer(32'h0000_5000, 6, 0, 1, 0, 0, 1);  // R11 writes while busy

    // random transfers
    for (int k = 0; k < 16; k++) begin
      run_xfer($urandom, $urandom_range(1, 9), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 4), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule